// File: doc/BRIEF.md
# SMBus Byte-Data Register Master

This block is an I2C master that a host drives through a small register bus. Each command runs one fixed-format SMBus byte-data transaction to a target device: either it writes one byte into a register of the target, or it reads one byte back from a register of the target. Software loads the target address, the register offset and, for a write, the data byte. It then sets a direction bit in the control register and waits for an event in the status register or on the interrupt line.

The serial lines are open drain. For each line the block has an enable output that pulls the line low when it is 1. SDA also has an input, which the engine samples. SCL is a plain output: the target cannot stretch the clock. The parameter `HALF_DIV` sets how many system clocks make up one SCL half-period.

Four event sources share one interrupt line: write completion, read completion, a NACK from the target, and an external interrupt pin of the target that is passed through. Each source has a sticky status bit that software clears by writing 1 to it, and a mask bit that keeps it off the interrupt line.

Top module: `smbus_byte_master`

## Requirements
- R1: After reset, every register reads 0 except the mask, which reads 0x0F. Both line enables are 0 and `irq` is 0.
- R2: The register offsets are: control 0, target address 1 (7 bits, bit 7 reads 0), register offset 2, write data 3, read data 4, status 5, mask 6. Registers 1, 2, 3 and 6 read back what was written. A read strobe returns the addressed value on `reg_rdata` one cycle later.
- R3: Writing control with bit 0 = 1 while idle runs a write transaction: START, address with R/W = 0, offset, data, STOP. When both bits 0 and 1 are set, bit 0 takes priority.
- R4: Writing control with bit 1 = 1 (and bit 0 = 0) while idle runs a read transaction: START, address with R/W = 0, offset, repeated START, address with R/W = 1, one received byte, STOP. The master leaves SDA released (NACK) in the ninth clock of the received byte. The received byte appears in read data.
- R5: Control bit 7 reads 1 while a transaction is in progress. A write to control during that time has no effect.
- R6: Status bit 1 is set when a write completes, bit 2 when a read completes, and bit 3 when the target NACKs the address, offset or data byte. A NACK stops the transfer with STOP, sets neither bit 1 nor bit 2, and leaves read data unchanged.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. If an event sets a bit in the same cycle as a clear, the set wins.
- R8: `irq` is 1 exactly when some status bit is 1 and its mask bit (same position) is 0.
- R9: Status bit 0 is set whenever `tgt_irq`, after two synchronizing flops, is 1. While the pin is held high, the bit comes back after a clear.
- R10: Every interval between SCL transitions within a transaction is a whole multiple of `HALF_DIV` clocks. SDA changes while SCL is high only to form START, repeated START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |
| tgt_irq | input | 1 | Interrupt pin of the target, active high |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The hardest states to reach from the ports are the NACK exits in the middle of a transaction and a control write that arrives while the engine is busy. The bench includes a bit-level open-drain target model that can refuse its address or refuse the data byte, so a transfer can be cut short after the first or the third byte. The directed sequence writes a read command right after starting a write, and then shows that no second transfer and no read-completion bit follow. Randomly mixed reads, writes and wrong addresses then check the returned bytes against a shadow copy of the target's registers.

// File: rtl/smbm_pkg.sv
package smbm_pkg;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_TADDR = 3'd1;
    localparam logic [2:0] A_OFFS  = 3'd2;
    localparam logic [2:0] A_WDATA = 3'd3;
    localparam logic [2:0] A_RDATA = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;
    localparam logic [2:0] A_MASK  = 3'd6;

    localparam int NSRC = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_BYTE, ST_ACK, ST_RSTART, ST_STOP, ST_FIN
    } eng_st_t;

    typedef enum logic [2:0] {
        K_ADDRW, K_OFFS, K_WDATA, K_ADDRR, K_RDATA
    } kind_t;

    typedef struct packed {
        logic nack;
        logic rd_done;
        logic wr_done;
    } evt_t;

    function automatic logic [7:0] tx_byte(kind_t k, logic [6:0] ta,
                                           logic [7:0] of, logic [7:0] wd);
        case (k)
            K_ADDRW: tx_byte = {ta, 1'b0};
            K_OFFS:  tx_byte = of;
            K_WDATA: tx_byte = wd;
            K_ADDRR: tx_byte = {ta, 1'b1};
            default: tx_byte = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smbm_engine.sv
module smbm_engine
    import smbm_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_wr,
    input  logic       go_rd,
    input  logic [6:0] taddr,
    input  logic [7:0] offs,
    input  logic [7:0] wdat,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output evt_t       evt,
    output logic [7:0] rbyte
);
    localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HCW-1:0] HLAST = HCW'(HALF_DIV - 1);

    eng_st_t        st;
    kind_t          kind;
    logic           ph;
    logic [HCW-1:0] hcnt;
    logic [2:0]     bitn;
    logic [7:0]     shreg;
    logic [7:0]     rx;
    logic           is_rd;
    logic           nack_seen;
    logic           tick;

    assign busy = (st != ST_IDLE);
    assign tick = busy && (hcnt == HLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            kind      <= K_ADDRW;
            ph        <= 1'b0;
            hcnt      <= '0;
            bitn      <= 3'd7;
            shreg     <= 8'hFF;
            rx        <= 8'h00;
            is_rd     <= 1'b0;
            nack_seen <= 1'b0;
            evt       <= '0;
            rbyte     <= 8'h00;
        end else begin
            evt <= '0;
            if (st == ST_IDLE) begin
                if (go_wr || go_rd) begin
                    st        <= ST_START;
                    ph        <= 1'b0;
                    hcnt      <= '0;
                    is_rd     <= go_rd && !go_wr;
                    kind      <= K_ADDRW;
                    nack_seen <= 1'b0;
                end
            end else if (!tick) begin
                hcnt <= hcnt + 1'b1;
            end else begin
                hcnt <= '0;
                ph   <= ~ph;
                case (st)
                    ST_START: if (ph) begin
                        st    <= ST_BYTE;
                        shreg <= tx_byte(kind, taddr, offs, wdat);
                        bitn  <= 3'd7;
                    end
                    ST_BYTE: if (ph) begin
                        rx    <= {rx[6:0], sda_in};
                        shreg <= {shreg[6:0], 1'b1};
                        if (bitn == 3'd0) st <= ST_ACK;
                        else              bitn <= bitn - 1'b1;
                    end
                    ST_ACK: if (ph) begin
                        bitn <= 3'd7;
                        if (kind != K_RDATA && sda_in) begin
                            nack_seen <= 1'b1;
                            st        <= ST_STOP;
                        end else begin
                            case (kind)
                                K_ADDRW: begin
                                    kind  <= K_OFFS;
                                    st    <= ST_BYTE;
                                    shreg <= tx_byte(K_OFFS, taddr, offs, wdat);
                                end
                                K_OFFS: begin
                                    if (is_rd) begin
                                        kind <= K_ADDRR;
                                        st   <= ST_RSTART;
                                    end else begin
                                        kind  <= K_WDATA;
                                        st    <= ST_BYTE;
                                        shreg <= tx_byte(K_WDATA, taddr, offs, wdat);
                                    end
                                end
                                K_ADDRR: begin
                                    kind  <= K_RDATA;
                                    st    <= ST_BYTE;
                                    shreg <= 8'hFF;
                                end
                                K_RDATA: begin
                                    rbyte <= rx;
                                    st    <= ST_STOP;
                                end
                                default: st <= ST_STOP;
                            endcase
                        end
                    end
                    ST_RSTART: begin
                        st <= ST_START;
                        ph <= 1'b0;
                    end
                    ST_STOP: if (ph) begin
                        st <= ST_FIN;
                        ph <= 1'b0;
                    end
                    ST_FIN: begin
                        st          <= ST_IDLE;
                        ph          <= 1'b0;
                        evt.wr_done <= !nack_seen && !is_rd;
                        evt.rd_done <= !nack_seen && is_rd;
                        evt.nack    <= nack_seen;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (st)
            ST_START:  sda_oe = ph;
            ST_BYTE:   begin scl_oe = !ph; sda_oe = !shreg[7]; end
            ST_ACK:    scl_oe = !ph;
            ST_RSTART: scl_oe = 1'b1;
            ST_STOP:   begin scl_oe = !ph; sda_oe = 1'b1; end
            default:   ;
        endcase
    end

    a_r10_scl_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_oe) |-> $past(tick));

    a_r10_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BYTE && $past(st) == ST_BYTE && !scl_oe && !$past(scl_oe))
        |-> $stable(sda_oe));

    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy);

endmodule

// File: rtl/smbm_regs.sv
module smbm_regs
    import smbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       busy,
    input  evt_t       evt,
    input  logic [7:0] rbyte,
    input  logic       tgt_irq,
    output logic       go_wr,
    output logic       go_rd,
    output logic [6:0] taddr,
    output logic [7:0] offs,
    output logic [7:0] wdat,
    output logic       irq
);
    logic [NSRC-1:0] stat;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic [1:0]      tsync;
    logic            ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL) && !busy;
    assign go_wr   = ctrl_wr && reg_wdata[0];
    assign go_rd   = ctrl_wr && !reg_wdata[0] && reg_wdata[1];

    assign set_v = {evt.nack, evt.rd_done, evt.wr_done, tsync[1]};
    assign clr_v = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NSRC-1:0] : '0;
    assign irq   = |(stat & ~mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            taddr     <= '0;
            offs      <= '0;
            wdat      <= '0;
            mask      <= '1;
            stat      <= '0;
            tsync     <= '0;
            reg_rdata <= '0;
        end else begin
            tsync <= {tsync[0], tgt_irq};
            stat  <= set_v | (stat & ~clr_v);
            if (reg_wr) begin
                case (reg_addr)
                    A_TADDR: taddr <= reg_wdata[6:0];
                    A_OFFS:  offs  <= reg_wdata;
                    A_WDATA: wdat  <= reg_wdata;
                    A_MASK:  mask  <= reg_wdata[NSRC-1:0];
                    default: ;
                endcase
            end
            if (reg_rd) begin
                case (reg_addr)
                    A_CTRL:  reg_rdata <= {busy, 7'd0};
                    A_TADDR: reg_rdata <= {1'b0, taddr};
                    A_OFFS:  reg_rdata <= offs;
                    A_WDATA: reg_rdata <= wdat;
                    A_RDATA: reg_rdata <= rbyte;
                    A_STAT:  reg_rdata <= {{(8-NSRC){1'b0}}, stat};
                    A_MASK:  reg_rdata <= {{(8-NSRC){1'b0}}, mask};
                    default: reg_rdata <= 8'h00;
                endcase
            end
        end
    end

    a_r6_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.nack, evt.rd_done, evt.wr_done}));

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_STAT && reg_wdata[1] && !evt.wr_done)
        |=> !stat[1]);

    a_r8_full_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq);

    a_r9_pin_sets: assert property (@(posedge clk) disable iff (rst)
        tsync[1] |=> stat[0]);

endmodule

// File: rtl/smbus_byte_master.sv
module smbus_byte_master
    import smbm_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in,
    input  logic       tgt_irq,
    output logic       irq
);
    logic       go_wr;
    logic       go_rd;
    logic       busy;
    logic [6:0] taddr;
    logic [7:0] offs;
    logic [7:0] wdat;
    logic [7:0] rbyte;
    evt_t       evt;

    smbm_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .evt(evt), .rbyte(rbyte), .tgt_irq(tgt_irq),
        .go_wr(go_wr), .go_rd(go_rd),
        .taddr(taddr), .offs(offs), .wdat(wdat), .irq(irq)
    );

    smbm_engine #(.HALF_DIV(HALF_DIV)) u_engine (
        .clk(clk), .rst(rst),
        .go_wr(go_wr), .go_rd(go_rd),
        .taddr(taddr), .offs(offs), .wdat(wdat),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .evt(evt), .rbyte(rbyte)
    );

endmodule

// File: tb/test_smbus_byte_master.sv
module test_smbus_byte_master;
    localparam int DIV = 4;
    localparam logic [6:0] TGT = 7'h35;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe, irq;
    logic       tgt_irq = 1'b0;
    logic       t_drv = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || t_drv);

    always #2.5 clk = ~clk;

    smbus_byte_master #(.HALF_DIV(DIV)) i_smbus_byte_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line),
        .tgt_irq(tgt_irq), .irq(irq)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // ---------------- target model ----------------
    logic [7:0] tmem [16];
    logic [7:0] emem [16];
    logic [7:0] sr, txb;
    logic [3:0] ptr = '0;
    logic p_scl = 1'b1, p_sda = 1'b1;
    int  cnt = 0, bi = 0;
    bit  active = 0, txm = 0, pend = 0, ok;
    bit  nack_data_f = 0;
    logic m_ack_bit = 1'b0;
    int  hi_chg = 0, scl_err = 0, ivl = 0;
    bit  ivl_valid = 0;

    always @(negedge clk) begin
        if (rst) begin
            p_scl = 1'b1; p_sda = 1'b1; active = 0; t_drv = 1'b0;
        end else begin
            ivl++;
            if (p_scl != scl_line) begin
                if (ivl_valid && (ivl % DIV) != 0) scl_err++;
                ivl_valid = 1; ivl = 0;
            end
            if (p_scl && scl_line && p_sda != sda_line) hi_chg++;
            if (p_scl && scl_line && p_sda && !sda_line) begin
                active = 1; bi = 0; cnt = 0; txm = 0; pend = 0; t_drv = 1'b0;
            end else if (p_scl && scl_line && !p_sda && sda_line) begin
                active = 0; t_drv = 1'b0; ivl_valid = 0;
            end else if (!p_scl && scl_line) begin
                cnt++;
                if (!txm && cnt <= 8) sr = {sr[6:0], sda_line};
                if (txm && cnt == 9) m_ack_bit = sda_line;
            end else if (p_scl && !scl_line && active) begin
                if (cnt == 8) begin
                    if (txm) t_drv = 1'b0;
                    else begin
                        ok = 1;
                        if (bi == 0) begin
                            ok = (sr[7:1] == TGT);
                            if (ok && sr[0]) begin pend = 1; txb = tmem[ptr]; end
                        end else if (bi == 1) ptr = sr[3:0];
                        else begin
                            ok = !nack_data_f;
                            if (ok) tmem[ptr] = sr;
                        end
                        bi++;
                        t_drv = ok;
                        if (!ok) active = 0;
                    end
                end else if (cnt == 9) begin
                    cnt = 0; t_drv = 1'b0;
                    if (pend) begin pend = 0; txm = 1; t_drv = !txb[7]; end
                    else txm = 0;
                end else if (txm && cnt >= 1 && cnt <= 7) begin
                    t_drv = !txb[7-cnt];
                end
            end
            p_scl = scl_line; p_sda = sda_line;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    function automatic int exp_stat(input bit rd, input bit good);
        return good ? (rd ? 4 : 2) : 8;
    endfunction

    task automatic setup(input logic [6:0] a, input logic [7:0] o, input logic [7:0] d);
        bus_wr(3'd1, {1'b0, a}); bus_wr(3'd2, o); bus_wr(3'd3, d);
    endtask

    task automatic wait_done(output logic [7:0] s);
        s = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            bus_rd(3'd5, s);
            if (s[3:1] != 3'b000) break;
        end
    endtask

    task automatic txn(input bit rd, input logic [6:0] a, input logic [7:0] o,
                       input logic [7:0] d, output logic [7:0] s, output int hc);
        int h0;
        setup(a, o, d);
        h0 = hi_chg;
        bus_wr(3'd0, rd ? 8'h02 : 8'h01);
        wait_done(s);
        hc = hi_chg - h0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R5 watchdog: actual=running expected=idle");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v, s;
        int hc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            tmem[i] = 8'(i * 17 + 3); emem[i] = tmem[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 irq", int'(irq), 0);
        for (int a = 0; a < 7; a++) begin
            bus_rd(3'(a), v);
            chk($sformatf("R1 reg%0d", a), int'(v), (a == 6) ? 8'h0F : 8'h00);
        end

        // R2 readback and address width
        bus_wr(3'd1, 8'hFF); bus_rd(3'd1, v); chk("R2 taddr 7 bits", int'(v), 8'h7F);
        bus_wr(3'd2, 8'h5A); bus_rd(3'd2, v); chk("R2 offset", int'(v), 8'h5A);
        bus_wr(3'd3, 8'hC3); bus_rd(3'd3, v); chk("R2 wdata", int'(v), 8'hC3);
        bus_wr(3'd6, 8'h00); bus_rd(3'd6, v); chk("R2 mask", int'(v), 8'h00);

        // R3 + R5 directed write, with a read command issued while busy
        setup(TGT, 8'h03, 8'hA5);
        bus_wr(3'd0, 8'h01);
        bus_rd(3'd0, v); chk("R5 busy flag", int'(v), 8'h80);
        bus_wr(3'd0, 8'h02);
        wait_done(s);
        chk("R6 write done status", int'(s), 8'h02);
        chk("R3 target got data", int'(tmem[3]), 8'hA5);
        emem[3] = 8'hA5;
        repeat (200) @(negedge clk);
        bus_rd(3'd0, v); chk("R5 ignored cmd: idle", int'(v), 8'h00);
        bus_rd(3'd5, v); chk("R5 ignored cmd: no read event", int'(v), 8'h02);
        chk("R8 irq on unmasked bit1", int'(irq), 1);
        bus_wr(3'd6, 8'h02); chk("R8 bit1 masked", int'(irq), 0);
        bus_wr(3'd6, 8'h0D); chk("R8 other masks", int'(irq), 1);
        bus_wr(3'd6, 8'h00);
        bus_wr(3'd5, 8'h00); bus_rd(3'd5, v); chk("R7 write 0 keeps", int'(v), 8'h02);
        bus_wr(3'd5, 8'h02); bus_rd(3'd5, v); chk("R7 write 1 clears", int'(v), 8'h00);
        chk("R8 irq low after clear", int'(irq), 0);

        // R3 both bits set: write wins
        setup(TGT, 8'h04, 8'h66);
        bus_wr(3'd0, 8'h03); wait_done(s);
        chk("R3 both bits -> write", int'(s), 8'h02);
        chk("R3 both bits data", int'(tmem[4]), 8'h66);
        emem[4] = 8'h66;
        bus_wr(3'd5, 8'h0F);

        // R4 directed read
        tmem[7] = 8'h3C; emem[7] = 8'h3C;
        m_ack_bit = 1'b0;
        txn(1, TGT, 8'h07, 8'h00, s, hc);
        chk("R6 read done status", int'(s), 8'h04);
        bus_rd(3'd4, v); chk("R4 read data", int'(v), 8'h3C);
        chk("R4 master NACK", int'(m_ack_bit), 1);
        chk("R10 read: start, rstart, stop", hc, 3);
        bus_wr(3'd5, 8'h0F);

        // R6 NACK on address, read data untouched
        txn(1, 7'h12, 8'h07, 8'h00, s, hc);
        chk("R6 addr NACK status", int'(s), 8'h08);
        bus_rd(3'd4, v); chk("R6 read data kept", int'(v), 8'h3C);
        chk("R10 nack: start, stop", hc, 2);
        bus_wr(3'd5, 8'h0F);

        // R6 NACK on data byte
        nack_data_f = 1;
        txn(0, TGT, 8'h07, 8'h99, s, hc);
        nack_data_f = 0;
        chk("R6 data NACK status", int'(s), 8'h08);
        chk("R6 data NACK target kept", int'(tmem[7]), 8'h3C);
        bus_wr(3'd5, 8'h0F);

        // R9 external target interrupt
        bus_wr(3'd6, 8'h0F);
        tgt_irq = 1'b1; repeat (4) @(negedge clk);
        bus_rd(3'd5, v); chk("R9 pin sets bit0", int'(v), 8'h01);
        chk("R8 bit0 masked", int'(irq), 0);
        bus_wr(3'd6, 8'h0E); chk("R8 bit0 unmasked", int'(irq), 1);
        bus_wr(3'd5, 8'h01); bus_rd(3'd5, v); chk("R9 held pin re-sets", int'(v), 8'h01);
        tgt_irq = 1'b0; repeat (4) @(negedge clk);
        bus_wr(3'd5, 8'h01); bus_rd(3'd5, v); chk("R9 clear after release", int'(v), 8'h00);
        chk("R8 irq low", int'(irq), 0);
        bus_wr(3'd6, 8'h00);

        // random mix
        for (int n = 0; n < 40; n++) begin
            bit rd, good;
            logic [3:0] o;
            logic [7:0] d;
            rd = 1'($urandom % 2);
            good = ($urandom % 6) != 0;
            o = 4'($urandom);
            d = 8'($urandom);
            txn(rd, good ? TGT : 7'h12, {4'h0, o}, d, s, hc);
            chk($sformatf("R6 random status n=%0d", n), int'(s), exp_stat(rd, good));
            chk($sformatf("R10 random hi changes n=%0d", n), hc, (rd && good) ? 3 : 2);
            if (good && !rd) emem[o] = d;
            if (good && rd) begin
                bus_rd(3'd4, v);
                chk($sformatf("R4 random read n=%0d", n), int'(v), int'(emem[o]));
            end
            if (good && !rd)
                chk($sformatf("R3 random write n=%0d", n), int'(tmem[o]), int'(d));
            bus_wr(3'd5, 8'h0F);
        end

        chk("R10 SCL intervals multiple of divider", scl_err, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule